// File: doc/BRIEF.md
# Prioritized Interrupt Level Controller

This block gathers twenty-eight interrupt request lines from around the chip and presents a single encoded priority level, the index of the winning source and a vector number to the processor core. Software gives each source a 3-bit level. A level of zero masks that source. The controller reports the highest level found among the pending sources. When several pending sources share that level, a fixed order decides: the source with the lower index wins.

The sources are numbered as follows:
- 0 to 5: external lines 1 to 6.
- 6 to 9: timers 0 to 3.
- 10 to 17: USB endpoints 0 to 7.
- 18 and 19: the two UARTs.
- 20: the periodic line-interface source.
- 21: the asynchronous line-interface source.
- 22: DMA.
- 23, 24 and 25: Ethernet transmit, receive and non-time-critical.
- 26: QSPI.
- 27: the watchdog timeout.

The six external lines are captured on their rising edge and are cleared by writing one. The internal sources are pending while their request line is high.

Until the vector base register has been written once after reset, the controller signals no interrupt. This keeps the core quiet until its stack memory has been set up. Each source also has a wakeup-enable bit. A pending source whose bit is set raises a wake request, so the device can leave power-down.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, level_o, src_o, vector_o, irq_valid_o, pend_o and wake_o are all zero.
- R2: level_o stays zero until vector_base_we_i has been asserted once after reset. The write arms the controller at that clock edge, and a pending level appears on level_o at the following edge.
- R3: A source whose programmed level is 0 never wins arbitration. If it is the only pending source, level_o is 0, although its bit in pend_o is still set.
- R4: level_o equals the highest programmed level among the pending sources. It is registered: a change in a request line of sources 6 to 27, or in a priority register, is seen on level_o one clock edge after the change takes effect.
- R5: When pending sources share the highest level, src_o reports the lowest index among them (index 0 is external line 1, index 27 is the watchdog). src_o is 0 when irq_valid_o is 0.
- R6: vector_o is formed from two fields: bits 7:5 are bits 7:5 of the vector base register, and bits 4:0 are src_o.
- R7: pend_o bits 0 to 5 are set by a rising edge on the matching request line and stay set after the line falls. Writing a one to the matching clr_i bit clears the bit at the next clock edge.
- R8: If a rising edge on an external line and a clear of the same bit fall in the same cycle, the pending bit is set.
- R9: pend_o bits 6 to 27 follow their request lines directly, and clr_i has no effect on them.
- R10: wake_o is high exactly when some source is pending and its wakeup-enable bit is set. wake_data_i is loaded into the wakeup-enable register when wake_we_i is high.
- R11: irq_valid_o is high exactly when level_o is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 28 | Request lines, indexed by source number |
| clr_i | input | 28 | Write-one-to-clear for external pending bits |
| prio_we_i | input | 1 | Priority write strobe |
| prio_sel_i | input | 5 | Source whose level is written |
| prio_data_i | input | 3 | Level value to write |
| vector_base_we_i | input | 1 | Vector base write strobe; arms recognition |
| vector_base_i | input | 8 | Vector base value |
| wake_we_i | input | 1 | Wakeup-enable write strobe |
| wake_data_i | input | 28 | Wakeup-enable bits |
| level_o | output | 3 | Active interrupt level (0 = none) |
| src_o | output | 5 | Index of the winning source |
| vector_o | output | 8 | Vector presented on acknowledge |
| irq_valid_o | output | 1 | Interrupt is being signalled |
| pend_o | output | 28 | Pending flags |
| wake_o | output | 1 | Wake request |

## Verification
Two functions can land in the same cycle: a rising edge on an external line, and a software clear of that same pending bit. The bench raises line 1 and asserts its clear bit in the same cycle. It then expects the pending bit to read one after the edge, because set must win.

A second overlap comes from the registered arbiter. A priority write and a live request meet in the same edge, so the bench checks that level_o still shows the old level right after the write and shows the new level one edge later.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  // source numbering; the order is also the tie-break order
  localparam int SRC_EXT_FIRST  = 0;
  localparam int SRC_TIMER0     = 6;
  localparam int SRC_USB_EP0    = 10;
  localparam int SRC_SERIAL0    = 18;
  localparam int SRC_LINE_PER   = 20;
  localparam int SRC_LINE_ASYNC = 21;
  localparam int SRC_DMA        = 22;
  localparam int SRC_ETH_TX     = 23;
  localparam int SRC_ETH_RX     = 24;
  localparam int SRC_ETH_MISC   = 25;
  localparam int SRC_QSPI       = 26;
  localparam int SRC_WDOG       = 27;

  typedef enum logic {ARB_IDLE = 1'b0, ARB_ARMED = 1'b1} arm_state_t;
endpackage

// File: rtl/irq_pend_capture.sv
module irq_pend_capture #(
  parameter int NSRC = 28,
  parameter int NEXT = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NEXT-1:0] prev_q, prev_d;
  logic [NEXT-1:0] epend_q, epend_d;
  logic [NEXT-1:0] rise;

  // external lines: rising edge sets, write-one clears, set wins (R7, R8)
  always_comb begin
    rise    = req_i[NEXT-1:0] & ~prev_q;
    prev_d  = req_i[NEXT-1:0];
    epend_d = (epend_q & ~clr_i[NEXT-1:0]) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      epend_q <= '0;
    end else begin
      prev_q  <= prev_d;
      epend_q <= epend_d;
    end
  end

  // internal sources are level sensitive; clr_i does not reach them (R9)
  for (genvar k = 0; k < NSRC; k++) begin : g_src
    if (k < NEXT) begin : g_edge
      assign pend_o[k] = epend_q[k];
    end else begin : g_level
      assign pend_o[k] = req_i[k];
    end
  end
endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank #(
  parameter int NSRC = 28,
  parameter int LVLW = 3,
  parameter int IDXW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic [IDXW-1:0]      sel_i,
  input  logic [LVLW-1:0]      data_i,
  output logic [NSRC*LVLW-1:0] prio_flat_o
);
  for (genvar k = 0; k < NSRC; k++) begin : g_reg
    logic            en;
    logic [LVLW-1:0] lvl_q, lvl_d;

    always_comb begin
      en    = we_i && (sel_i == IDXW'(k));
      lvl_d = en ? data_i : lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl_d;
    end

    assign prio_flat_o[k*LVLW +: LVLW] = lvl_q;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC = 28,
  parameter int LVLW = 3,
  parameter int IDXW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 armed_i,
  input  logic [NSRC-1:0]      pend_i,
  input  logic [NSRC*LVLW-1:0] prio_flat_i,
  output logic [LVLW-1:0]      level_o,
  output logic [IDXW-1:0]      idx_o,
  output logic                 valid_o
);
  logic [LVLW-1:0] max_lvl, level_d, level_q;
  logic [IDXW-1:0] win_idx, idx_d, idx_q;
  logic            hit, valid_d, valid_q;

  always_comb begin
    max_lvl = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (pend_i[k] && (prio_flat_i[k*LVLW +: LVLW] > max_lvl))
        max_lvl = prio_flat_i[k*LVLW +: LVLW];
    end
    // scan downward so the lowest matching index is taken last (R5)
    win_idx = '0;
    hit     = 1'b0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (pend_i[k] && (max_lvl != '0) && (prio_flat_i[k*LVLW +: LVLW] == max_lvl)) begin
        win_idx = IDXW'(k);
        hit     = 1'b1;
      end
    end
    valid_d = armed_i && hit;
    level_d = valid_d ? max_lvl : '0;
    idx_d   = valid_d ? win_idx : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      level_q <= level_d;
      idx_q   <= idx_d;
      valid_q <= valid_d;
    end
  end

  assign level_o = level_q;
  assign idx_o   = idx_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
  parameter int NSRC = 28,
  parameter int NEXT = 6,
  parameter int LVLW = 3,
  parameter int VECW = 8,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            prio_we_i,
  input  logic [IDXW-1:0] prio_sel_i,
  input  logic [LVLW-1:0] prio_data_i,
  input  logic            vector_base_we_i,
  input  logic [VECW-1:0] vector_base_i,
  input  logic            wake_we_i,
  input  logic [NSRC-1:0] wake_data_i,
  output logic [LVLW-1:0] level_o,
  output logic [IDXW-1:0] src_o,
  output logic [VECW-1:0] vector_o,
  output logic            irq_valid_o,
  output logic [NSRC-1:0] pend_o,
  output logic            wake_o
);
  import irq_lvl_pkg::*;

  arm_state_t             arm_q, arm_d;
  logic [VECW-1:0]        vbase_q, vbase_d;
  logic [NSRC-1:0]        wake_en_q, wake_en_d;
  logic [NSRC-1:0]        pend;
  logic [NSRC*LVLW-1:0]   prio_flat;
  logic [IDXW-1:0]        win_idx;

  // next state for the control registers
  always_comb begin
    arm_d     = vector_base_we_i ? ARB_ARMED : arm_q;
    vbase_d   = vector_base_we_i ? vector_base_i : vbase_q;
    wake_en_d = wake_we_i ? wake_data_i : wake_en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q     <= ARB_IDLE;
      vbase_q   <= '0;
      wake_en_q <= '0;
    end else begin
      arm_q     <= arm_d;
      vbase_q   <= vbase_d;
      wake_en_q <= wake_en_d;
    end
  end

  irq_pend_capture #(.NSRC(NSRC), .NEXT(NEXT)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .clr_i  (clr_i),
    .pend_o (pend)
  );

  irq_prio_bank #(.NSRC(NSRC), .LVLW(LVLW), .IDXW(IDXW)) u_prio (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_i        (prio_we_i),
    .sel_i       (prio_sel_i),
    .data_i      (prio_data_i),
    .prio_flat_o (prio_flat)
  );

  irq_arbiter #(.NSRC(NSRC), .LVLW(LVLW), .IDXW(IDXW)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .armed_i     (arm_q == ARB_ARMED),
    .pend_i      (pend),
    .prio_flat_i (prio_flat),
    .level_o     (level_o),
    .idx_o       (win_idx),
    .valid_o     (irq_valid_o)
  );

  assign src_o    = win_idx;
  assign vector_o = {vbase_q[VECW-1:IDXW], win_idx};
  assign pend_o   = pend;
  assign wake_o   = |(pend & wake_en_q);
endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk #(
  parameter int NSRC = 28,
  parameter int NEXT = 6,
  parameter int LVLW = 3,
  parameter int IDXW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] req_i,
  input logic [NSRC-1:0] clr_i,
  input logic            vector_base_we_i,
  input logic [NSRC-1:0] pend_o,
  input logic [LVLW-1:0] level_o,
  input logic [IDXW-1:0] src_o,
  input logic            irq_valid_o
);
  logic            seen_q;
  logic            live_q;
  logic [NEXT-1:0] req_prev_q;
  logic [NEXT-1:0] rise_q;
  logic [NEXT-1:0] hold_q;
  logic [NSRC-1:0] pend_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q      <= 1'b0;
      live_q      <= 1'b0;
      req_prev_q  <= '0;
      rise_q      <= '0;
      hold_q      <= '0;
      pend_prev_q <= '0;
    end else begin
      seen_q      <= seen_q | vector_base_we_i;
      live_q      <= 1'b1;
      req_prev_q  <= req_i[NEXT-1:0];
      rise_q      <= req_i[NEXT-1:0] & ~req_prev_q;
      hold_q      <= pend_o[NEXT-1:0] & ~clr_i[NEXT-1:0];
      pend_prev_q <= pend_o;
    end
  end

  AST_UNARMED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (level_o == '0)); // R2

  AST_VALID_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o == (level_o != '0)); // R11

  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> ((hold_q & ~pend_o[NEXT-1:0]) == '0)); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> ((rise_q & ~pend_o[NEXT-1:0]) == '0)); // R8

  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && irq_valid_o) |-> pend_prev_q[src_o]); // R4

  AST_IDLE_SRC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid_o |-> (src_o == '0)); // R5
endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(
  .NSRC(NSRC), .NEXT(NEXT), .LVLW(LVLW), .IDXW(IDXW)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_i            (req_i),
  .clr_i            (clr_i),
  .vector_base_we_i (vector_base_we_i),
  .pend_o           (pend_o),
  .level_o          (level_o),
  .src_o            (src_o),
  .irq_valid_o      (irq_valid_o)
);

// File: tb/irq_level_arbiter_test.sv
`timescale 1ns/1ps
module irq_level_arbiter_test;
  localparam int NSRC = 28;

  logic            clk;
  logic            rst_n;
  logic [NSRC-1:0] req_i, clr_i, wake_data_i;
  logic            prio_we_i, vector_base_we_i, wake_we_i;
  logic [4:0]      prio_sel_i;
  logic [2:0]      prio_data_i;
  logic [7:0]      vector_base_i;
  logic [2:0]      level_o;
  logic [4:0]      src_o;
  logic [7:0]      vector_o;
  logic            irq_valid_o, wake_o;
  logic [NSRC-1:0] pend_o;

  int total = 0;
  int bad   = 0;

  irq_level_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(clr_i),
    .prio_we_i(prio_we_i), .prio_sel_i(prio_sel_i), .prio_data_i(prio_data_i),
    .vector_base_we_i(vector_base_we_i), .vector_base_i(vector_base_i),
    .wake_we_i(wake_we_i), .wake_data_i(wake_data_i),
    .level_o(level_o), .src_o(src_o), .vector_o(vector_o),
    .irq_valid_o(irq_valid_o), .pend_o(pend_o), .wake_o(wake_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // request pattern (internal sources only), expected level, expected source
  localparam logic [35:0] TBL [10] = '{
    {28'h0000080, 3'd1, 5'd7},
    {28'h00000C0, 3'd2, 5'd6},
    {28'h0001400, 3'd5, 5'd10},
    {28'h0009000, 3'd5, 5'd12},
    {28'h8100000, 3'd7, 5'd20},
    {28'h8000400, 3'd7, 5'd27},
    {28'h0800000, 3'd0, 5'd0},
    {28'h0800100, 3'd1, 5'd8},
    {28'h0000000, 3'd0, 5'd0},
    {28'h0008200, 3'd3, 5'd15}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_prio(input int idx, input logic [2:0] val);
    prio_we_i   = 1'b1;
    prio_sel_i  = 5'(idx);
    prio_data_i = val;
    tick();
    prio_we_i   = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_i = '0; clr_i = '0; wake_data_i = '0;
    prio_we_i = 1'b0; prio_sel_i = '0; prio_data_i = '0;
    vector_base_we_i = 1'b0; vector_base_i = '0; wake_we_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 level", 32'(level_o), 0);
    chk("R1 valid", 32'(irq_valid_o), 0);
    chk("R1 pend",  32'(pend_o), 0);
    chk("R1 vector", 32'(vector_o), 0);
    chk("R1 wake", 32'(wake_o), 0);

    // R2: no level before the vector base is written
    wr_prio(6, 3'd2);
    req_i[6] = 1'b1;
    tick(); tick();
    chk("R2 unarmed level", 32'(level_o), 0);
    chk("R9 pend follows req", 32'(pend_o[6]), 1);
    vector_base_we_i = 1'b1; vector_base_i = 8'hA0;
    tick();
    vector_base_we_i = 1'b0;
    chk("R2 level one edge after arm", 32'(level_o), 0);
    tick();
    chk("R2 level after arm", 32'(level_o), 2);
    chk("R5 src", 32'(src_o), 6);
    chk("R6 vector", 32'(vector_o), 32'hA6);

    // R10 wakeup
    wake_we_i = 1'b1; wake_data_i = 28'h0000040;
    tick();
    wake_we_i = 1'b0;
    chk("R10 wake set", 32'(wake_o), 1);
    req_i[6] = 1'b0;
    tick();
    chk("R10 wake clear", 32'(wake_o), 0);

    // priorities for internal sources
    for (int k = 7; k < NSRC; k++) wr_prio(k, 3'd1);
    wr_prio(10, 3'd5); wr_prio(12, 3'd5); wr_prio(15, 3'd3);
    wr_prio(20, 3'd7); wr_prio(27, 3'd7); wr_prio(23, 3'd0);

    // table: R3 masking, R4 max level, R5 ties, R6 vector, R11 valid
    for (int i = 0; i < 10; i++) begin
      req_i = TBL[i][35:8];
      tick();
      chk("R4 level", 32'(level_o), 32'(TBL[i][7:5]));
      chk("R5 src", 32'(src_o), 32'(TBL[i][4:0]));
      chk("R6 vector", 32'(vector_o), 32'({3'b101, TBL[i][4:0]}));
      chk("R11 valid", 32'(irq_valid_o), 32'(TBL[i][7:5] != 3'd0));
      if (TBL[i][35:8] == 28'h0800000) chk("R3 masked still pending", 32'(pend_o[23]), 1);
    end

    // R4 registered timing on priority change
    req_i = 28'h0000100;
    tick();
    chk("R4 before change", 32'(level_o), 1);
    prio_we_i = 1'b1; prio_sel_i = 5'd8; prio_data_i = 3'd6;
    tick();
    prio_we_i = 1'b0;
    chk("R4 old level after write", 32'(level_o), 1);
    tick();
    chk("R4 new level", 32'(level_o), 6);
    chk("R4 src", 32'(src_o), 8);
    req_i = '0;
    tick();

    // R7 external edge capture and write-one clear
    wr_prio(0, 3'd4); wr_prio(3, 3'd4); wr_prio(1, 3'd2);
    req_i[3] = 1'b1;
    tick();
    req_i[3] = 1'b0;
    chk("R7 ext captured", 32'(pend_o[3]), 1);
    chk("R7 level lags capture", 32'(level_o), 0);
    tick();
    chk("R7 ext level", 32'(level_o), 4);
    chk("R7 ext src", 32'(src_o), 3);
    tick(); tick();
    chk("R7 ext held", 32'(pend_o[3]), 1);
    req_i[0] = 1'b1;
    tick();
    req_i[0] = 1'b0;
    tick();
    chk("R5 ext tie lowest index", 32'(src_o), 0);
    clr_i[0] = 1'b1;
    tick();
    clr_i[0] = 1'b0;
    chk("R7 ext cleared", 32'(pend_o[0]), 0);
    tick();
    chk("R7 src after clear", 32'(src_o), 3);

    // R8 set beats clear in the same cycle
    req_i[1] = 1'b1; clr_i[1] = 1'b1;
    tick();
    clr_i[1] = 1'b0;
    chk("R8 set wins", 32'(pend_o[1]), 1);

    // R9 clear ignored on internal source
    req_i[7] = 1'b1; clr_i[7] = 1'b1;
    tick();
    clr_i[7] = 1'b0;
    chk("R9 clr ignored", 32'(pend_o[7]), 1);
    chk("R4 level unchanged", 32'(level_o), 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule